// File: doc/BRIEF.md
# Set/Clear-Enable Interrupt Controller

The block collects interrupt requests from a parameterised number of sources into a pending register. It gates that register with an enable mask and drives one interrupt request line to the processor. Software never writes the mask directly. One register address ORs bits into the mask and another address removes bits from it. A read of the set address returns the whole mask. Three sources are marked at elaboration as latched: a periodic tick and two timer counters. A single-cycle pulse on one of these sources sets its pending bit, and the bit stays set until software writes the end-of-interrupt address that belongs to that source. All other sources are level sources, and their pending bit follows the input.

Software reads two views of the pending bits. The status view is pending AND mask. The raw view is the pending register unmasked. Read data comes back one clock after the read request, together with a valid strobe. Addresses that are unmapped or write-only read as all ones.

Register offsets, as byte addresses: status 0x00 (read), raw 0x04 (read), enable-set 0x08 (write ORs, read gives mask), enable-clear 0x0C (write), tick end-of-interrupt 0x10, first timer end-of-interrupt 0x14, second timer end-of-interrupt 0x18 (write, data ignored).

Top module: `intc_setclr`

## Requirements
- R1: A write to 0x08 leaves the mask equal to its previous value OR the write data.
- R2: A write to 0x0C clears every mask bit that is 1 in the write data and leaves the other bits unchanged.
- R3: A read of 0x08 returns the current enable mask.
- R4: A read of 0x00 returns pending AND mask.
- R5: A read of 0x04 returns the pending register regardless of the mask.
- R6: `irq` is high exactly when some bit is set in both pending and mask, and it follows the registers in the same cycle.
- R7: A one-cycle high pulse on a latched source (TICK_IDX, TC0_IDX, TC1_IDX) sets its pending bit after the next clock edge, and the bit stays set after the pulse ends.
- R8: A write of any data to 0x10, 0x14 or 0x18 clears the pending bit of the tick source, the first timer or the second timer respectively, and no other bit.
- R9: If a latched source pulses in the same cycle as the write to its end-of-interrupt address, the pending bit ends up set.
- R10: The pending bit of a level source equals its input as sampled at the previous clock edge, and end-of-interrupt writes have no effect on it.
- R11: Read data and `bus_rvalid` appear one cycle after `bus_rd`. Reads of 0x0C, 0x10, 0x14, 0x18 or any unmapped address return all ones.
- R12: Reset clears the pending register and the mask. Writes to 0x00 and 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | NUM_SRC | Source inputs: pulses for latched sources, levels for the others |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle after each read |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NUM_SRC=16 and places the latched sources at bits 15, 0 and 7. This puts them at both ends of the pending vector and in the middle. An index or shift slip at either edge therefore shows up in the raw readback. The narrower data width keeps the all-ones value of unmapped reads distinct from the default 32-bit width. The level sources lie next to the latched bits. This shows whether end-of-interrupt writes and same-cycle set-versus-clear races stay confined to their own bit.

// File: rtl/intc_setclr_pkg.sv
package intc_setclr_pkg;

    // Byte offsets of the register slots
    localparam int unsigned OFF_STATUS   = 32'h00;
    localparam int unsigned OFF_RAW      = 32'h04;
    localparam int unsigned OFF_EN_SET   = 32'h08;
    localparam int unsigned OFF_EN_CLR   = 32'h0C;
    localparam int unsigned OFF_EOI_TICK = 32'h10;
    localparam int unsigned OFF_EOI_TC0  = 32'h14;
    localparam int unsigned OFF_EOI_TC1  = 32'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_RAW,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_EOI_TICK,
        SEL_EOI_TC0,
        SEL_EOI_TC1
    } reg_sel_e;

endpackage

// File: rtl/intc_addr_decode.sv
module intc_addr_decode
    import intc_setclr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFF_STATUS))        sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFF_RAW))      sel = SEL_RAW;
        else if (addr == ADDR_W'(OFF_EN_SET))   sel = SEL_EN_SET;
        else if (addr == ADDR_W'(OFF_EN_CLR))   sel = SEL_EN_CLR;
        else if (addr == ADDR_W'(OFF_EOI_TICK)) sel = SEL_EOI_TICK;
        else if (addr == ADDR_W'(OFF_EOI_TC0))  sel = SEL_EOI_TC0;
        else if (addr == ADDR_W'(OFF_EOI_TC1))  sel = SEL_EOI_TC1;
    end

endmodule

// File: rtl/intc_enable_reg.sv
module intc_enable_reg #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask
);

    logic [NUM_SRC-1:0] set_bits;
    logic [NUM_SRC-1:0] clr_bits;

    always_comb begin
        set_bits = set_stb ? wdata : '0;
        clr_bits = clr_stb ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask | set_bits) & ~clr_bits;
    end

endmodule

// File: rtl/intc_pending_bank.sv
module intc_pending_bank #(
    parameter int NUM_SRC  = 32,
    parameter int TICK_IDX = 4,
    parameter int TC0_IDX  = 8,
    parameter int TC1_IDX  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               eoi_tick,
    input  logic               eoi_tc0,
    input  logic               eoi_tc1,
    output logic [NUM_SRC-1:0] pend
);

    localparam logic [NUM_SRC-1:0] LATCH_MASK =
        (NUM_SRC'(1) << TICK_IDX) | (NUM_SRC'(1) << TC0_IDX) | (NUM_SRC'(1) << TC1_IDX);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (LATCH_MASK[i]) begin : g_latched
            logic clr_i;
            always_comb begin
                clr_i = 1'b0;
                if (i == TICK_IDX && eoi_tick) clr_i = 1'b1;
                if (i == TC0_IDX  && eoi_tc0)  clr_i = 1'b1;
                if (i == TC1_IDX  && eoi_tc1)  clr_i = 1'b1;
            end
            // the new event takes precedence over the clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pend[i] <= 1'b0;
                else        pend[i] <= evt[i] | (pend[i] & ~clr_i);
            end
        end else begin : g_level
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pend[i] <= 1'b0;
                else        pend[i] <= evt[i];
            end
        end
    end

endmodule

// File: rtl/intc_read_port.sv
module intc_read_port
    import intc_setclr_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  reg_sel_e           sel,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] rdata,
    output logic               rvalid
);

    logic [NUM_SRC-1:0] rd_mux;

    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = pend & mask;
            SEL_RAW:    rd_mux = pend;
            SEL_EN_SET: rd_mux = mask;
            default:    rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/intc_setclr.sv
module intc_setclr
    import intc_setclr_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int ADDR_W   = 8,
    parameter int TICK_IDX = 4,
    parameter int TC0_IDX  = 8,
    parameter int TC1_IDX  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               bus_rvalid,
    output logic               irq
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] en_mask;
    logic [NUM_SRC-1:0] pend_q;
    logic               wr_set, wr_clr, wr_eoi_tick, wr_eoi_tc0, wr_eoi_tc1;

    intc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        wr_set      = bus_wr && (sel == SEL_EN_SET);
        wr_clr      = bus_wr && (sel == SEL_EN_CLR);
        wr_eoi_tick = bus_wr && (sel == SEL_EOI_TICK);
        wr_eoi_tc0  = bus_wr && (sel == SEL_EOI_TC0);
        wr_eoi_tc1  = bus_wr && (sel == SEL_EOI_TC1);
    end

    intc_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (wr_set),
        .clr_stb (wr_clr),
        .wdata   (bus_wdata),
        .mask    (en_mask)
    );

    intc_pending_bank #(
        .NUM_SRC  (NUM_SRC),
        .TICK_IDX (TICK_IDX),
        .TC0_IDX  (TC0_IDX),
        .TC1_IDX  (TC1_IDX)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (src_evt),
        .eoi_tick (wr_eoi_tick),
        .eoi_tc0  (wr_eoi_tc0),
        .eoi_tc1  (wr_eoi_tc1),
        .pend     (pend_q)
    );

    intc_read_port #(.NUM_SRC(NUM_SRC)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (bus_rd),
        .sel    (sel),
        .pend   (pend_q),
        .mask   (en_mask),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    assign irq = |(pend_q & en_mask);

endmodule

// File: rtl/intc_setclr_chk.sv
module intc_setclr_chk
    import intc_setclr_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int ADDR_W   = 8,
    parameter int TICK_IDX = 4,
    parameter int TC0_IDX  = 8,
    parameter int TC1_IDX  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_evt,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               bus_rvalid,
    input logic               irq,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] pend
);

    localparam logic [NUM_SRC-1:0] LATCH_MASK =
        (NUM_SRC'(1) << TICK_IDX) | (NUM_SRC'(1) << TC0_IDX) | (NUM_SRC'(1) << TC1_IDX);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_enable_or_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN_SET)) |=> (mask == ($past(mask) | $past(bus_wdata))));

    assert_enable_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN_CLR)) |=> ((mask & $past(bus_wdata)) == '0));

    assert_status_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_STATUS)) |=> ((bus_rdata != '0) == $past(irq)));

    assert_latched_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ((($past(src_evt) & LATCH_MASK) & ~pend) == '0));

    assert_tick_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EOI_TICK) && !src_evt[TICK_IDX]) |=> !pend[TICK_IDX]);

    assert_level_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ((pend & ~LATCH_MASK) == ($past(src_evt) & ~LATCH_MASK)));

    assert_read_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (bus_rvalid == $past(bus_rd)));

endmodule

bind intc_setclr intc_setclr_chk #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .TICK_IDX (TICK_IDX),
    .TC0_IDX  (TC0_IDX),
    .TC1_IDX  (TC1_IDX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt    (src_evt),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .mask       (en_mask),
    .pend       (pend_q)
);

// File: tb/intc_setclr_tb_top.sv
`timescale 1ns/1ps
module intc_setclr_tb_top;

    localparam int NS   = 16;
    localparam int AW   = 8;
    localparam int TICK = 15;
    localparam int TC0  = 0;
    localparam int TC1  = 7;
    localparam int LVL  = 3;
    localparam logic [NS-1:0] LATCH = (NS'(1) << TICK) | (NS'(1) << TC0) | (NS'(1) << TC1);

    localparam logic [AW-1:0] A_STATUS = 8'h00;
    localparam logic [AW-1:0] A_RAW    = 8'h04;
    localparam logic [AW-1:0] A_SET    = 8'h08;
    localparam logic [AW-1:0] A_CLR    = 8'h0C;
    localparam logic [AW-1:0] A_ETICK  = 8'h10;
    localparam logic [AW-1:0] A_ETC0   = 8'h14;
    localparam logic [AW-1:0] A_ETC1   = 8'h18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_evt = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NS-1:0] bus_wdata = '0;
    logic [NS-1:0] bus_rdata;
    logic          bus_rvalid;
    logic          irq;

    always #2 clk = ~clk;

    intc_setclr #(
        .NUM_SRC (NS), .ADDR_W (AW), .TICK_IDX (TICK), .TC0_IDX (TC0), .TC1_IDX (TC1)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .src_evt (src_evt), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_rvalid (bus_rvalid), .irq (irq)
    );

    typedef struct {
        logic [NS-1:0] val;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // bench model
    logic [NS-1:0] m_mask = '0;
    logic [NS-1:0] m_pend = '0;   // latched part only

    function automatic logic [NS-1:0] raw_exp();
        return m_pend | (src_evt & ~LATCH);
    endfunction

    task automatic note(input bit ok, input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when the design returns it
    always @(negedge clk) begin
        if (bus_rvalid && !done) begin
            if (sb_q.size() == 0) begin
                note(1'b0, "R11 unexpected rvalid", bus_rdata, '0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                note(bus_rdata === e.val, e.tag, bus_rdata, e.val);
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [NS-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [NS-1:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        e.val = exp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_evt[idx] = 1'b1;
        @(negedge clk);
        src_evt[idx] = 1'b0;
        m_pend[idx] = 1'b1;
    endtask

    task automatic check_irq(input string tag);
        logic e;
        e = |(raw_exp() & m_mask);
        note(irq === e, tag, {{(NS-1){1'b0}}, irq}, {{(NS-1){1'b0}}, e});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        bus_read(A_STATUS, '0, "R12 reset status");
        bus_read(A_RAW,    '0, "R12 reset raw");
        bus_read(A_SET,    '0, "R12 reset mask");
        check_irq("R6 irq low after reset");

        // R1 / R3 enable set ORs in
        bus_write(A_SET, 16'h8081); m_mask |= 16'h8081;
        bus_write(A_SET, 16'h0008); m_mask |= 16'h0008;
        bus_read(A_SET, m_mask, "R1 R3 mask after two set writes");

        // R2 enable clear
        bus_write(A_CLR, 16'h8001); m_mask &= ~16'h8001;
        bus_read(A_SET, m_mask, "R2 mask after clear");

        // R7 / R5 / R4 latched tick while masked off
        pulse(TICK);
        bus_read(A_RAW, raw_exp(), "R5 R7 raw after tick pulse");
        bus_read(A_STATUS, raw_exp() & m_mask, "R4 status masked");
        check_irq("R6 irq low while tick masked");

        bus_write(A_SET, 16'h8000); m_mask |= 16'h8000;
        check_irq("R6 irq high after enabling tick");
        bus_read(A_STATUS, raw_exp() & m_mask, "R4 status tick enabled");

        // R8 each end-of-interrupt clears only its own bit
        pulse(TC0);
        pulse(TC1);
        bus_read(A_RAW, raw_exp(), "R7 raw three latched");
        bus_write(A_ETICK, 16'h0000); m_pend[TICK] = 1'b0;
        bus_read(A_RAW, raw_exp(), "R8 tick eoi clears only tick");
        bus_write(A_ETC1, 16'hFFFF); m_pend[TC1] = 1'b0;
        bus_read(A_RAW, raw_exp(), "R8 tc1 eoi clears only tc1");
        bus_read(A_STATUS, raw_exp() & m_mask, "R4 status after eoi");
        check_irq("R6 irq after eoi");
        bus_write(A_ETC0, 16'h1234); m_pend[TC0] = 1'b0;
        bus_read(A_RAW, raw_exp(), "R8 tc0 eoi clears tc0");

        // R9 set beats same-cycle clear
        @(negedge clk);
        src_evt[TICK] = 1'b1; bus_wr = 1'b1; bus_addr = A_ETICK; bus_wdata = '0;
        @(negedge clk);
        src_evt[TICK] = 1'b0; bus_wr = 1'b0;
        m_pend[TICK] = 1'b1;
        bus_read(A_RAW, raw_exp(), "R9 simultaneous set and eoi");
        bus_write(A_ETICK, 16'h0000); m_pend[TICK] = 1'b0;
        bus_read(A_RAW, raw_exp(), "R8 tick cleared after race");

        // R10 level source follows input, eoi has no effect
        @(negedge clk);
        src_evt[LVL] = 1'b1;
        bus_read(A_RAW, raw_exp(), "R10 level source high");
        check_irq("R6 irq from level source");
        bus_write(A_ETC0, 16'hFFFF);
        bus_write(A_ETICK, 16'hFFFF);
        bus_read(A_RAW, raw_exp(), "R10 eoi no effect on level bit");
        @(negedge clk);
        src_evt[LVL] = 1'b0;
        bus_read(A_RAW, raw_exp(), "R10 level source dropped");
        check_irq("R6 irq low after level drop");

        // R12 writes to read-only views are ignored
        pulse(TC1);
        bus_write(A_RAW, 16'h0000);
        bus_write(A_STATUS, 16'hFFFF);
        bus_read(A_RAW, raw_exp(), "R12 raw unchanged by writes");
        bus_read(A_SET, m_mask, "R12 mask unchanged by writes");

        // R11 write-only and unmapped reads
        bus_read(8'h1C, '1, "R11 unmapped read");
        bus_read(A_CLR, '1, "R11 clear address read");
        bus_read(A_ETC1, '1, "R11 eoi address read");

        repeat (3) @(negedge clk);
        note(sb_q.size() == 0, "R11 all reads answered", NS'(sb_q.size()), '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule